// File: doc/BRIEF.md
# Prioritized interrupt request controller

This block collects interrupt requests for a small 8-bit processor and presents the single winning request to it. Requests are held in a pending register with one bit per source. Internal sources such as timers set their pending bit directly through a one-cycle strobe. External pins are sampled every clock into a separate line-state register. Only a change of level against that stored state is acted on, and a rising level latches a request.

The first external input has two modes, chosen by a control input. In level mode the request follows the pin: releasing the pin drops the request, and an acknowledge leaves it pending. In edge mode the request is latched and an acknowledge clears it.

The pending bits are scanned from index 0 upward. Sources at or above the first external index pass through an enable mask, and lower sources cannot be masked. The winner's index and a valid flag are driven combinationally to the processor, which returns an acknowledge strobe carrying the index it accepted. Software can also drop a single request through a clear-register write. An accepted acknowledge takes the processor out of its halted state.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset, the pending register, the line-state register and the enable mask are all zero, so `irq_valid_o`=0, `irq_idx_o`=0 and `halted_o`=0. An external request latched before any mask write therefore stays invisible.
- R2: A high bit k on `int_set_i` sets pending bit k at the next clock edge. It does not touch the line-state register, so a later rise on a pin is still seen as a new edge.
- R3: External pin k maps to source index EXT_BASE+k (default 8). A pin whose sampled level goes from 0 to 1 sets its pending bit. A pin held at the same level creates no further request.
- R4: When pin 0 falls in level mode (`ext0_edge_i`=0), pending bit EXT_BASE is cleared. When it falls in edge mode (`ext0_edge_i`=1), the bit is kept.
- R5: An acknowledge (`ack_i`=1) of a pending index clears that bit. The exception is index EXT_BASE in level mode, which stays pending.
- R6: An acknowledge of an index whose pending bit is 0 has no effect on any request or on `halted_o`.
- R7: The lowest-numbered enabled pending index wins. When there is no winner, `irq_idx_o` reads 0.
- R8: Indices at or above EXT_BASE are gated by the enable mask, which is written whole through `mask_we_i`/`mask_wdata_i`. Indices below EXT_BASE are never masked. Masking hides a request but does not discard it.
- R9: A clear write of value v (`swclr_we_i`) clears pending bit v-2 when SWI_IDX (default 2) <= v-2 <= 15. Any other value is ignored.
- R10: When a set and a clear reach the same pending bit in the same cycle, the bit ends up set.
- R11: `halt_req_i` sets `halted_o` at the next edge. An acknowledge of a pending index clears it, and the wake wins over a halt request in the same cycle.
- R12: In edge mode, an acknowledge of EXT_BASE clears its pending bit even while pin 0 is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| int_set_i | input | 16 | Internal source set strobes, one per index |
| ext_line_i | input | 4 | External interrupt pin levels |
| ext0_edge_i | input | 1 | Pin 0 mode: 0 level, 1 edge |
| mask_we_i | input | 1 | Enable mask write strobe |
| mask_wdata_i | input | 16 | New enable mask |
| swclr_we_i | input | 1 | Software request clear strobe |
| swclr_wdata_i | input | 8 | Clear value (index + 2) |
| ack_i | input | 1 | Acknowledge strobe |
| ack_idx_i | input | 4 | Index being acknowledged |
| halt_req_i | input | 1 | Processor enters halt |
| irq_valid_o | output | 1 | A request is presented |
| irq_idx_o | output | 4 | Winning source index |
| halted_o | output | 1 | Processor is halted |

## Verification
Every stimulus, whether a pin change, set strobe, acknowledge, mask write, clear write or halt request, lands in a register at the next rising edge. Its effect reaches `irq_valid_o`, `irq_idx_o` and `halted_o` through combinational logic immediately after that edge, so every result is due exactly one edge after the stimulus. The driver applies inputs on the falling edge and queues the expected output triple for that cycle. The monitor pops one entry and compares it 1 ns after the following rising edge, which keeps every comparison in the cycle where the result first becomes due. Hidden state, such as a masked request or a request kept past an acknowledge, is made visible by a later mask change or by the next winner in priority order.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned NSRC_DEF     = 16;
  localparam int unsigned NEXT_DEF     = 4;
  localparam int unsigned EXT_BASE_DEF = 8;
  localparam int unsigned SWI_IDX_DEF  = 2;
  localparam int unsigned CLR_OFS      = 2;

  typedef enum logic {
    MODE_LEVEL = 1'b0,
    MODE_EDGE  = 1'b1
  } ext0_mode_e;
endpackage

// File: rtl/irq_line_track.sv
module irq_line_track #(
  parameter int unsigned NEXT = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NEXT-1:0] line_i,
  output logic [NEXT-1:0] state_o,
  output logic [NEXT-1:0] rise_o,
  output logic [NEXT-1:0] fall_o
);
  logic [NEXT-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= '0;
    else         state_q <= line_i;
  end

  // act only where the level differs from what was stored
  assign rise_o  = line_i & ~state_q;
  assign fall_o  = ~line_i & state_q;
  assign state_o = state_q;
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int unsigned NSRC = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o
);
  logic [NSRC-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;  // set wins
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned NSRC     = 16,
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned EXT_BASE = 8
) (
  input  logic [NSRC-1:0]  pend_i,
  input  logic [NSRC-1:0]  mask_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [NSRC-1:0] ALWAYS_ON = (NSRC'(1) << EXT_BASE) - NSRC'(1);

  logic [NSRC-1:0] eff;
  assign eff = pend_i & (mask_i | ALWAYS_ON);

  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (eff[i]) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NSRC     = NSRC_DEF,
  parameter int unsigned NEXT     = NEXT_DEF,
  parameter int unsigned EXT_BASE = EXT_BASE_DEF,
  parameter int unsigned SWI_IDX  = SWI_IDX_DEF,
  localparam int unsigned IDX_W   = $clog2(NSRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  int_set_i,
  input  logic [NEXT-1:0]  ext_line_i,
  input  logic             ext0_edge_i,
  input  logic             mask_we_i,
  input  logic [NSRC-1:0]  mask_wdata_i,
  input  logic             swclr_we_i,
  input  logic [7:0]       swclr_wdata_i,
  input  logic             ack_i,
  input  logic [IDX_W-1:0] ack_idx_i,
  input  logic             halt_req_i,
  output logic             irq_valid_o,
  output logic [IDX_W-1:0] irq_idx_o,
  output logic             halted_o
);
  logic [NEXT-1:0] line_q, rise, fall;
  logic [NSRC-1:0] pend_q, mask_q, set_vec, clr_vec;
  logic            halted_q;
  ext0_mode_e      ext0_mode;
  logic            lvl_mode, ack_hit, ack_keep, ack_clr, sw_ok, lvl_drop;
  logic [8:0]      sw_tgt;

  assign ext0_mode = ext0_mode_e'(ext0_edge_i);
  assign lvl_mode  = (ext0_mode == MODE_LEVEL);

  irq_line_track #(.NEXT(NEXT)) u_line (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (ext_line_i),
    .state_o(line_q),
    .rise_o (rise),
    .fall_o (fall)
  );

  always_comb begin
    set_vec = int_set_i;
    for (int k = 0; k < int'(NEXT); k++) begin
      if (rise[k]) set_vec[EXT_BASE + k] = 1'b1;
    end
  end

  assign ack_hit  = ack_i && pend_q[ack_idx_i];
  assign ack_keep = (ack_idx_i == IDX_W'(EXT_BASE)) && lvl_mode;
  assign ack_clr  = ack_hit && !ack_keep;
  assign sw_tgt   = {1'b0, swclr_wdata_i} - 9'(CLR_OFS);
  assign sw_ok    = swclr_we_i && (sw_tgt >= 9'(SWI_IDX)) && (sw_tgt < 9'(NSRC));
  assign lvl_drop = fall[0] && lvl_mode;

  always_comb begin
    for (int i = 0; i < int'(NSRC); i++) begin
      clr_vec[i] = (ack_clr && (ack_idx_i == IDX_W'(i))) ||
                   (sw_ok && (sw_tgt == 9'(i)));
    end
    if (lvl_drop) clr_vec[EXT_BASE] = 1'b1;
  end

  irq_pend_reg #(.NSRC(NSRC)) u_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_vec),
    .clr_i (clr_vec),
    .pend_o(pend_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         halted_q <= 1'b0;
    else if (ack_hit)    halted_q <= 1'b0;
    else if (halt_req_i) halted_q <= 1'b1;
  end

  irq_prio_pick #(
    .NSRC    (NSRC),
    .IDX_W   (IDX_W),
    .EXT_BASE(EXT_BASE)
  ) u_pick (
    .pend_i (pend_q),
    .mask_i (mask_q),
    .valid_o(irq_valid_o),
    .idx_o  (irq_idx_o)
  );

  assign halted_o = halted_q;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int unsigned NSRC     = 16,
  parameter int unsigned NEXT     = 4,
  parameter int unsigned EXT_BASE = 8,
  parameter int unsigned IDX_W    = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NSRC-1:0]  pend_q,
  input logic [NSRC-1:0]  mask_q,
  input logic [NSRC-1:0]  set_vec,
  input logic [NSRC-1:0]  int_set_i,
  input logic [NEXT-1:0]  line_q,
  input logic [NEXT-1:0]  ext_line_i,
  input logic             ext0_edge_i,
  input logic             ack_i,
  input logic [IDX_W-1:0] ack_idx_i,
  input logic             irq_valid_o,
  input logic [IDX_W-1:0] irq_idx_o,
  input logic             halted_o
);
  localparam logic [NSRC-1:0] LOW = (NSRC'(1) << EXT_BASE) - NSRC'(1);

  logic [NSRC-1:0] below_win;
  assign below_win = (NSRC'(1) << irq_idx_o) - NSRC'(1);

  for (genvar k = 0; k < NSRC; k++) begin : g_set
    assert_set_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int_set_i[k] |=> pend_q[k]);
  end

  assert_rise_latch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_line_i[0] && !line_q[0]) |=> pend_q[EXT_BASE]);

  assert_level_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && ack_idx_i == IDX_W'(EXT_BASE) && !ext0_edge_i && pend_q[EXT_BASE]
     && ext_line_i[0]) |=> pend_q[EXT_BASE]);

  assert_ack_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && pend_q[ack_idx_i] && !set_vec[ack_idx_i] && ack_idx_i != IDX_W'(EXT_BASE))
    |=> !pend_q[$past(ack_idx_i)]);

  assert_win_pending_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> pend_q[irq_idx_o]);

  assert_no_lower_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> ((pend_q & (mask_q | LOW) & below_win) == '0));

  assert_mask_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_valid_o && irq_idx_o >= IDX_W'(EXT_BASE)) |-> mask_q[irq_idx_o]);

  assert_wake_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && pend_q[ack_idx_i]) |=> !halted_o);
endmodule

bind irq_ctrl_top irq_ctrl_chk #(
  .NSRC    (NSRC),
  .NEXT    (NEXT),
  .EXT_BASE(EXT_BASE),
  .IDX_W   (IDX_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pend_q     (pend_q),
  .mask_q     (mask_q),
  .set_vec    (set_vec),
  .int_set_i  (int_set_i),
  .line_q     (line_q),
  .ext_line_i (ext_line_i),
  .ext0_edge_i(ext0_edge_i),
  .ack_i      (ack_i),
  .ack_idx_i  (ack_idx_i),
  .irq_valid_o(irq_valid_o),
  .irq_idx_o  (irq_idx_o),
  .halted_o   (halted_o)
);

// File: tb/sim_irq_ctrl_top.sv
`timescale 1ns/1ps
module sim_irq_ctrl_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [15:0] int_set_i;
  logic [3:0]  ext_line_i;
  logic        ext0_edge_i;
  logic        mask_we_i;
  logic [15:0] mask_wdata_i;
  logic        swclr_we_i;
  logic [7:0]  swclr_wdata_i;
  logic        ack_i;
  logic [3:0]  ack_idx_i;
  logic        halt_req_i;
  logic        irq_valid_o;
  logic [3:0]  irq_idx_o;
  logic        halted_o;

  always #2 clk_i = ~clk_i;

  irq_ctrl_top u0 (
    .clk_i, .rst_ni, .int_set_i, .ext_line_i, .ext0_edge_i,
    .mask_we_i, .mask_wdata_i, .swclr_we_i, .swclr_wdata_i,
    .ack_i, .ack_idx_i, .halt_req_i,
    .irq_valid_o, .irq_idx_o, .halted_o
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  string      tag_q[$];
  logic [5:0] exp_q[$];
  logic [5:0] e_cur;
  string      t_cur;

  // one expected {valid, idx, halted} per clocked stimulus
  task automatic tick(input string tag, input logic v, input logic [3:0] idx, input logic h);
    tag_q.push_back(tag);
    exp_q.push_back({v, idx, h});
    @(negedge clk_i);
    int_set_i  = '0;
    mask_we_i  = 1'b0;
    swclr_we_i = 1'b0;
    ack_i      = 1'b0;
    halt_req_i = 1'b0;
  endtask

  task automatic ack(input logic [3:0] idx);
    ack_i     = 1'b1;
    ack_idx_i = idx;
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (exp_q.size() > 0) begin
        e_cur = exp_q.pop_front();
        t_cur = tag_q.pop_front();
        total++;
        if ({irq_valid_o, irq_idx_o, halted_o} !== e_cur) begin
          bad++;
          $display("FAIL %s: got v=%0b idx=%0d h=%0b exp v=%0b idx=%0d h=%0b", t_cur,
                   irq_valid_o, irq_idx_o, halted_o, e_cur[5], e_cur[4:1], e_cur[0]);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      bad++;
      $display("FAIL watchdog (all R): got hang exp finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; int_set_i = '0; ext_line_i = '0; ext0_edge_i = 1'b0;
    mask_we_i = 1'b0; mask_wdata_i = '0; swclr_we_i = 1'b0; swclr_wdata_i = '0;
    ack_i = 1'b0; ack_idx_i = '0; halt_req_i = 1'b0;
    repeat (3) @(negedge clk_i);
    total++;
    if ({irq_valid_o, irq_idx_o, halted_o} !== 6'b0) begin
      bad++;
      $display("FAIL R1 reset: got v=%0b idx=%0d h=%0b exp 0 0 0", irq_valid_o, irq_idx_o, halted_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    ext_line_i[1] = 1'b1;                   tick("R1 mask zero hides pin1", 0, 0, 0);
    mask_we_i = 1; mask_wdata_i = 16'hFFFF; tick("R8 unmask shows idx9", 1, 9, 0);
    ack(9);                                 tick("R5 ack clears idx9", 0, 0, 0);
                                            tick("R3 held level no rerequest", 0, 0, 0);
    ext_line_i[1] = 1'b0;                   tick("R3 pin1 fall idle", 0, 0, 0);
    int_set_i = 16'h1008;                   tick("R7 idx3 beats idx12", 1, 3, 0);
    ack(3);                                 tick("R5 R7 next winner idx12", 1, 12, 0);
    mask_we_i = 1; mask_wdata_i = 16'h0000; tick("R8 mask hides idx12", 0, 0, 0);
    int_set_i = 16'h0001;                   tick("R2 R8 idx0 unmaskable", 1, 0, 0);
    ack(5);                                 tick("R6 ack idle idx5", 1, 0, 0);
    halt_req_i = 1;                         tick("R11 halt", 1, 0, 1);
    ack(7);                                 tick("R6 idle ack no wake", 1, 0, 1);
    ack(0);                                 tick("R11 ack wakes", 0, 0, 0);
    mask_we_i = 1; mask_wdata_i = 16'hFFFF; tick("R8 masked request kept", 1, 12, 0);
    swclr_we_i = 1; swclr_wdata_i = 8'd14;  tick("R9 clear v14 drops idx12", 0, 0, 0);
    int_set_i = 16'h0002;                   tick("R2 set idx1", 1, 1, 0);
    swclr_we_i = 1; swclr_wdata_i = 8'd3;   tick("R9 v3 below range ignored", 1, 1, 0);
    swclr_we_i = 1; swclr_wdata_i = 8'd18;  tick("R9 v18 above range ignored", 1, 1, 0);
    ack(1);                                 tick("R5 ack idx1", 0, 0, 0);
    ext_line_i[0] = 1'b1;                   tick("R3 pin0 rise level mode", 1, 8, 0);
    ack(8);                                 tick("R5 level ack keeps idx8", 1, 8, 0);
    ext_line_i[0] = 1'b0;                   tick("R4 level fall clears idx8", 0, 0, 0);
    ext0_edge_i = 1'b1; ext_line_i[0] = 1'b1; tick("R3 pin0 rise edge mode", 1, 8, 0);
    ext_line_i[0] = 1'b0;                   tick("R4 edge fall keeps idx8", 1, 8, 0);
    ack(8);                                 tick("R12 edge ack clears idx8", 0, 0, 0);
    ext_line_i[0] = 1'b1;                   tick("R12 rise again", 1, 8, 0);
    ack(8);                                 tick("R12 ack clears with pin high", 0, 0, 0);
    int_set_i = 16'h0020;                   tick("R2 set idx5", 1, 5, 0);
    ack(5); int_set_i = 16'h0020;           tick("R10 set beats ack", 1, 5, 0);
    swclr_we_i = 1; swclr_wdata_i = 8'd7; int_set_i = 16'h0020; tick("R10 set beats sw clear", 1, 5, 0);
    ack(5);                                 tick("R5 ack idx5", 0, 0, 0);
    int_set_i = 16'h0400;                   tick("R2 internal idx10", 1, 10, 0);
    ack(10);                                tick("R5 ack idx10", 0, 0, 0);
    ext_line_i[2] = 1'b1;                   tick("R2 R3 pin2 still new edge", 1, 10, 0);
    ack(10); halt_req_i = 1;                tick("R11 wake beats halt", 0, 0, 0);

    @(posedge clk_i);
    #2;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule